// File: doc/BRIEF.md
# Interrupt Poll and Vector Arbiter

This block sits beside the instruction sequencer of an 8-bit accumulator-style CPU core and decides when an interrupt may be taken and which vector the core must fetch. It samples the maskable request line, the edge-triggered non-maskable request line and the CPU reset line once per CPU cycle, at the moment phase two falls. It keeps its own copy of the interrupt-disable flag, so that each flag-changing instruction affects the poll with the right timing. It raises a pending request when the sequencer marks a poll cycle, and at the next opcode fetch it takes over the core for the seven-cycle interrupt sequence.

While that sequence runs, the block drives a cycle index and a vector select. A non-maskable request that arrives while a software-break or maskable sequence is running, and before the vector is fetched, redirects the sequence to its own vector. A low reset line holds the core in one extra cycle and then runs the same seven-cycle sequence with the reset vector.

Top module: `irq_poll_unit`

## Requirements
- R1: Request and reset lines are sampled only on the falling edge of phase two. A pulse that comes and goes inside a single CPU cycle without being present at that edge has no effect.
- R2: A high-to-low transition of `nmi_n` sets a pending flag that stays set until a sequence serving it begins. A line held low gives exactly one service.
- R3: The maskable line is level-sensitive and gated by the mask copy being clear. A level that goes away before a poll leaves no request.
- R4: New requests are recognised only in a tick where `poll` is high and `poll_block` is low. `int_req` then stays high until a sequence starts.
- R5: A return-from-interrupt event (`ev_rti`) loads `pull_i` into the mask before the poll of the same tick, so the restored value governs that poll.
- R6: Clear, set and pull-flags events (`ev_cli`, `ev_sei`, `ev_plp`) change the mask only after the tick they occur in, so a poll in that tick uses the old value.
- R7: When a sequence starts from `int_req`, the non-maskable source wins over the maskable one. `vec_sel` encodes none=0, reset=1, non-maskable=2, maskable/break=3, and `vec_addr` is FFFC, FFFA or FFFE.
- R8: A sequence starts at a tick with `op_fetch` and `int_req` high, or with `brk_go` high. It clears `int_req` and holds `seq_force` high for 7 ticks with `seq_cyc` running 0 to 6. It also sets the mask.
- R9: A pending or newly detected non-maskable request at the tick where `seq_cyc` is 4 changes a maskable/break sequence to vector 2 and consumes the request. A request detected later leaves the vector unchanged and stays pending.
- R10: A tick with `cpu_res_n` low forces one hold cycle with `vec_sel`=1 and `seq_cyc`=0. After release, seven cycles 0 to 6 follow, eight forced ticks in all.
- R11: After `rst_n`, `int_req` and `seq_force` are low and `vec_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| ph1 | input | 1 | CPU phase one level |
| ph2 | input | 1 | CPU phase two level |
| irq_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, active low, edge |
| cpu_res_n | input | 1 | CPU reset line, active low |
| poll | input | 1 | Sequencer marks this cycle as a poll point |
| poll_block | input | 1 | Suppresses the poll (branch-specific cycles) |
| op_fetch | input | 1 | Sequencer is at an opcode fetch |
| brk_go | input | 1 | Software break instruction starts its sequence |
| ev_rti | input | 1 | Return-from-interrupt restores the flag |
| ev_cli | input | 1 | Clear-disable instruction |
| ev_sei | input | 1 | Set-disable instruction |
| ev_plp | input | 1 | Pull-flags instruction |
| pull_i | input | 1 | Flag value pulled from the stack |
| int_req | output | 1 | Pending interrupt request to the sequencer |
| seq_force | output | 1 | Forces the interrupt sequence |
| seq_cyc | output | 3 | Cycle index within the sequence |
| vec_sel | output | 2 | Vector select |
| vec_addr | output | 16 | Vector low-byte address |

## Verification
The maskable line is tried masked and unmasked, held across a poll and released before one, and with polls that are suppressed or absent. These cases separate level gating from latching and from poll qualification. Each of the four flag events is paired with a poll in the same tick, which tells the immediate update apart from the delayed ones. The non-maskable line is tried as a glitch between sampling edges, as a single edge, as a long low level, together with a maskable level, and at the last tick before the vector fetch and the first tick after it. These cases separate edge latching, priority and the hijack window.

// File: rtl/ipu_pkg.sv
// Shared types for the interrupt poll unit.
package ipu_pkg;
    typedef enum logic [1:0] {
        VS_NONE = 2'd0,
        VS_RES  = 2'd1,
        VS_NMI  = 2'd2,
        VS_IRQ  = 2'd3
    } vsel_t;
endpackage

// File: rtl/ipu_phase_sample.sv
// Finds the falling edge of phase two and samples the request lines there.
// Assumes ph1 and ph2 do not overlap and that each is high for at least
// one clk cycle.
module ipu_phase_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic ph1,
    input  logic ph2,
    input  logic irq_n,
    input  logic nmi_n,
    input  logic cpu_res_n,
    input  logic nmi_take,
    output logic tick,
    output logic irq_lvl,
    output logic nmi_seen,
    output logic res_low
);
    logic ph2_q;
    logic nmi_prev_q;
    logic nmi_pend_q;
    logic nmi_edge;

    // Remember phase two so that its falling edge can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) ph2_q <= 1'b0;
        else        ph2_q <= ph2;
    end

    // Combinational view of the sample point and the sampled lines.
    always_comb begin
        tick     = ph2_q & ~ph2 & ph1;
        irq_lvl  = ~irq_n;
        res_low  = ~cpu_res_n;
        nmi_edge = nmi_prev_q & ~nmi_n;
        nmi_seen = nmi_pend_q | nmi_edge;
    end

    // Latch non-maskable edges until a sequence consumes them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_prev_q <= 1'b1;
            nmi_pend_q <= 1'b0;
        end else if (tick) begin
            nmi_prev_q <= nmi_n;
            nmi_pend_q <= nmi_seen & ~nmi_take & ~res_low;
        end
    end
endmodule

// File: rtl/ipu_mask_track.sv
// Keeps the poll-side copy of the interrupt-disable flag. The restore done by
// a return-from-interrupt is visible in the same tick; the other updates
// are visible from the next tick on.
module ipu_mask_track (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic res_low,
    input  logic seq_started,
    input  logic ev_rti,
    input  logic ev_cli,
    input  logic ev_sei,
    input  logic ev_plp,
    input  logic pull_i,
    output logic mask_eff
);
    logic mask_q;

    // Mask value used by the poll in the current tick.
    always_comb begin
        mask_eff = ev_rti ? pull_i : mask_q;
    end

    // Register the mask update, applied at the end of the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
        end else if (tick) begin
            if (res_low || seq_started) mask_q <= 1'b1;
            else if (ev_rti || ev_plp)  mask_q <= pull_i;
            else if (ev_cli)            mask_q <= 1'b0;
            else if (ev_sei)            mask_q <= 1'b1;
        end
    end
endmodule

// File: rtl/ipu_seq_ctl.sv
// Runs the forced interrupt sequence: the reset hold cycle, the cycle count
// and the vector choice, including the late switch to the non-maskable
// vector. Assumes the vector is fetched from cycle VEC_FETCH onward.
module ipu_seq_ctl
    import ipu_pkg::*;
#(
    parameter int SEQ_LEN   = 7,
    parameter int VEC_FETCH = 5,
    localparam int CYC_W    = $clog2(SEQ_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             res_low,
    input  logic             start_req,
    input  logic             brk_go,
    input  logic             nmi_seen,
    output logic             seq_on,
    output logic [CYC_W-1:0] cyc,
    output vsel_t            vec,
    output logic             nmi_take,
    output logic             started
);
    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(SEQ_LEN - 1);
    localparam logic [CYC_W-1:0] HIJ_CYC  = CYC_W'(VEC_FETCH - 1);

    logic             on_q;
    logic             hold_q;
    logic [CYC_W-1:0] cyc_q;
    vsel_t            vec_q;
    logic             idle_go;
    logic             hijack;
    logic             take_at_start;

    // Decide starts and the vector switch for this tick.
    always_comb begin
        idle_go       = ~on_q & (start_req | brk_go);
        take_at_start = ~on_q & start_req & nmi_seen;
        hijack        = on_q & ~hold_q & (cyc_q == HIJ_CYC) &
                        (vec_q == VS_IRQ) & nmi_seen;
        nmi_take      = tick & ~res_low & (hijack | take_at_start);
        started       = tick & ~res_low & idle_go;
        seq_on        = on_q;
        cyc           = cyc_q;
        vec           = vec_q;
    end

    // Advance the sequence state once per CPU cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q   <= 1'b0;
            hold_q <= 1'b0;
            cyc_q  <= '0;
            vec_q  <= VS_NONE;
        end else if (tick) begin
            if (res_low) begin
                on_q   <= 1'b1;
                hold_q <= 1'b1;
                cyc_q  <= '0;
                vec_q  <= VS_RES;
            end else if (on_q) begin
                if (hold_q) begin
                    hold_q <= 1'b0;
                end else if (cyc_q == LAST_CYC) begin
                    on_q  <= 1'b0;
                    cyc_q <= '0;
                    vec_q <= VS_NONE;
                end else begin
                    cyc_q <= cyc_q + 1'b1;
                    if (hijack) vec_q <= VS_NMI;
                end
            end else if (idle_go) begin
                on_q  <= 1'b1;
                cyc_q <= '0;
                vec_q <= (start_req && nmi_seen) ? VS_NMI : VS_IRQ;
            end
        end
    end
endmodule

// File: rtl/irq_poll_unit.sv
// Top of the interrupt poll unit: poll qualification and the pending request,
// plus the vector address. Assumes the sequencer raises poll and op_fetch in
// separate CPU cycles, the fetch following the poll.
module irq_poll_unit
    import ipu_pkg::*;
#(
    parameter int          SEQ_LEN   = 7,
    parameter int          VEC_FETCH = 5,
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] RES_VEC   = 16'hFFFC,
    parameter logic [15:0] NMI_VEC   = 16'hFFFA,
    parameter logic [15:0] IRQ_VEC   = 16'hFFFE,
    localparam int         CYC_W     = $clog2(SEQ_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ph1,
    input  logic              ph2,
    input  logic              irq_n,
    input  logic              nmi_n,
    input  logic              cpu_res_n,
    input  logic              poll,
    input  logic              poll_block,
    input  logic              op_fetch,
    input  logic              brk_go,
    input  logic              ev_rti,
    input  logic              ev_cli,
    input  logic              ev_sei,
    input  logic              ev_plp,
    input  logic              pull_i,
    output logic              int_req,
    output logic              seq_force,
    output logic [CYC_W-1:0]  seq_cyc,
    output logic [1:0]        vec_sel,
    output logic [ADDR_W-1:0] vec_addr
);
    logic  tick;
    logic  irq_lvl;
    logic  nmi_seen;
    logic  res_low;
    logic  nmi_take;
    logic  started;
    logic  mask_eff;
    logic  seq_on;
    logic  req_q;
    logic  start_req;
    vsel_t vec;

    ipu_phase_sample u_sample (
        .clk(clk), .rst_n(rst_n), .ph1(ph1), .ph2(ph2),
        .irq_n(irq_n), .nmi_n(nmi_n), .cpu_res_n(cpu_res_n),
        .nmi_take(nmi_take), .tick(tick), .irq_lvl(irq_lvl),
        .nmi_seen(nmi_seen), .res_low(res_low)
    );

    ipu_mask_track u_mask (
        .clk(clk), .rst_n(rst_n), .tick(tick), .res_low(res_low),
        .seq_started(started), .ev_rti(ev_rti), .ev_cli(ev_cli),
        .ev_sei(ev_sei), .ev_plp(ev_plp), .pull_i(pull_i),
        .mask_eff(mask_eff)
    );

    ipu_seq_ctl #(.SEQ_LEN(SEQ_LEN), .VEC_FETCH(VEC_FETCH)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .res_low(res_low),
        .start_req(start_req), .brk_go(brk_go), .nmi_seen(nmi_seen),
        .seq_on(seq_on), .cyc(seq_cyc), .vec(vec),
        .nmi_take(nmi_take), .started(started)
    );

    // A pending request is taken at the next opcode fetch.
    always_comb begin
        start_req = op_fetch & req_q;
    end

    // Pending request: set at qualified polls, cleared when a sequence starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (tick) begin
            if (res_low || started)
                req_q <= 1'b0;
            else if (poll && !poll_block && !seq_on)
                req_q <= req_q | nmi_seen | (irq_lvl & ~mask_eff);
        end
    end

    // Drive the outputs and map the vector select to its address.
    always_comb begin
        int_req   = req_q;
        seq_force = seq_on;
        vec_sel   = vec;
        unique case (vec)
            VS_RES:  vec_addr = ADDR_W'(RES_VEC);
            VS_NMI:  vec_addr = ADDR_W'(NMI_VEC);
            VS_IRQ:  vec_addr = ADDR_W'(IRQ_VEC);
            default: vec_addr = '0;
        endcase
    end
endmodule

// File: rtl/ipu_checker.sv
// Temporal checks on the interrupt poll unit, bound to the top module.
module ipu_checker #(
    parameter int SEQ_LEN   = 7,
    parameter int VEC_FETCH = 5,
    localparam int CYC_W    = $clog2(SEQ_LEN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             cpu_res_n,
    input logic             op_fetch,
    input logic             int_req,
    input logic             seq_force,
    input logic [CYC_W-1:0] seq_cyc,
    input logic [1:0]       vec_sel
);
    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(SEQ_LEN - 1);
    localparam logic [CYC_W-1:0] VF_CYC   = CYC_W'(VEC_FETCH);

    p_sample_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(seq_cyc) && $stable(int_req) && $stable(vec_sel)));

    p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cpu_res_n && op_fetch && int_req && !seq_force)
        |=> (!int_req && seq_force && seq_cyc == '0));

    p_idle_no_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_force == (vec_sel != 2'd0));

    p_vec_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cpu_res_n && seq_force && seq_cyc >= VF_CYC &&
         seq_cyc != LAST_CYC) |=> $stable(vec_sel));

    p_reset_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cpu_res_n) |=> (seq_force && vec_sel == 2'd1));
endmodule

bind irq_poll_unit ipu_checker #(.SEQ_LEN(SEQ_LEN), .VEC_FETCH(VEC_FETCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cpu_res_n(cpu_res_n),
    .op_fetch(op_fetch), .int_req(int_req), .seq_force(seq_force),
    .seq_cyc(seq_cyc), .vec_sel(vec_sel)
);

// File: tb/tb_irq_poll_unit.sv
`timescale 1ns/1ps
module tb_irq_poll_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ph1 = 1'b1, ph2 = 1'b0;
    logic irq_n = 1'b1, nmi_n = 1'b1, cpu_res_n = 1'b1;
    logic poll = 1'b0, poll_block = 1'b0, op_fetch = 1'b0, brk_go = 1'b0;
    logic ev_rti = 1'b0, ev_cli = 1'b0, ev_sei = 1'b0, ev_plp = 1'b0, pull_i = 1'b0;
    logic        int_req, seq_force;
    logic [2:0]  seq_cyc;
    logic [1:0]  vec_sel;
    logic [15:0] vec_addr;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_poll_unit dut (
        .clk(clk), .rst_n(rst_n), .ph1(ph1), .ph2(ph2), .irq_n(irq_n),
        .nmi_n(nmi_n), .cpu_res_n(cpu_res_n), .poll(poll),
        .poll_block(poll_block), .op_fetch(op_fetch), .brk_go(brk_go),
        .ev_rti(ev_rti), .ev_cli(ev_cli), .ev_sei(ev_sei), .ev_plp(ev_plp),
        .pull_i(pull_i), .int_req(int_req), .seq_force(seq_force),
        .seq_cyc(seq_cyc), .vec_sel(vec_sel), .vec_addr(vec_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One CPU cycle: phase two, then phase one; the sample edge falls inside.
    task automatic step();
        @(negedge clk) begin ph1 = 1'b0; ph2 = 1'b1; end
        @(negedge clk);
        @(negedge clk) begin ph1 = 1'b1; ph2 = 1'b0; end
        @(negedge clk);
    endtask

    task automatic clr();
        poll = 0; poll_block = 0; op_fetch = 0; brk_go = 0;
        ev_rti = 0; ev_cli = 0; ev_sei = 0; ev_plp = 0; pull_i = 0;
    endtask

    task automatic serve(input logic [1:0] es, input logic [15:0] ea, input string tag);
        op_fetch = 1; step(); clr();
        chk({tag, " R8 force"}, seq_force, 1);
        chk({tag, " R8 cyc0"}, seq_cyc, 0);
        chk({tag, " R8 req clear"}, int_req, 0);
        chk({tag, " R7 vec_sel"}, vec_sel, es);
        chk({tag, " R7 vec_addr"}, vec_addr, ea);
        for (int i = 1; i < 7; i++) begin
            step();
            chk({tag, " R8 cyc"}, seq_cyc, i);
        end
        step();
        chk({tag, " R8 end"}, seq_force, 0);
    endtask

    task automatic t_reset_state();
        chk("R11 int_req", int_req, 0);
        chk("R11 seq_force", seq_force, 0);
        chk("R11 vec_sel", vec_sel, 0);
    endtask

    task automatic t_irq_level();
        irq_n = 0; poll = 1; step(); clr();
        chk("R3 masked", int_req, 0);
        ev_cli = 1; poll = 1; step(); clr();
        chk("R6 cli old mask", int_req, 0);
        poll = 1; step(); clr();
        chk("R3 unmasked", int_req, 1);
        serve(2'd3, 16'hFFFE, "irq");
        poll = 1; step(); clr();
        chk("R8 mask set by seq", int_req, 0);
        irq_n = 1;
        ev_cli = 1; step(); clr();
        irq_n = 0; step(); irq_n = 1; step();
        poll = 1; step(); clr();
        chk("R3 not latched", int_req, 0);
    endtask

    task automatic t_poll_gate();
        irq_n = 0; step();
        chk("R4 no poll", int_req, 0);
        poll = 1; poll_block = 1; step(); clr();
        chk("R4 blocked", int_req, 0);
        poll = 1; step(); clr();
        chk("R4 poll taken", int_req, 1);
        irq_n = 1; step();
        chk("R4 req held", int_req, 1);
        serve(2'd3, 16'hFFFE, "poll");
    endtask

    task automatic t_rti();
        irq_n = 0; ev_rti = 1; pull_i = 0; poll = 1; step(); clr();
        chk("R5 rti unmask now", int_req, 1);
        irq_n = 1; serve(2'd3, 16'hFFFE, "rti");
        ev_cli = 1; step(); clr();
        irq_n = 0; ev_rti = 1; pull_i = 1; poll = 1; step(); clr();
        chk("R5 rti mask now", int_req, 0);
        irq_n = 1;
    endtask

    task automatic t_late_flags();
        irq_n = 0; ev_plp = 1; pull_i = 0; poll = 1; step(); clr();
        chk("R6 plp old mask", int_req, 0);
        poll = 1; step(); clr();
        chk("R6 plp applied", int_req, 1);
        irq_n = 1; serve(2'd3, 16'hFFFE, "plp");
        ev_cli = 1; step(); clr();
        irq_n = 0; ev_sei = 1; poll = 1; step(); clr();
        chk("R6 sei old mask", int_req, 1);
        irq_n = 1; serve(2'd3, 16'hFFFE, "sei");
    endtask

    task automatic t_nmi();
        // Glitch between sample edges is invisible.
        @(negedge clk) begin ph1 = 1'b0; ph2 = 1'b1; nmi_n = 1'b0; end
        @(negedge clk);
        @(negedge clk) begin nmi_n = 1'b1; ph1 = 1'b1; ph2 = 1'b0; end
        @(negedge clk);
        poll = 1; step(); clr();
        chk("R1 glitch ignored", int_req, 0);
        nmi_n = 0; step(); nmi_n = 1; step();
        chk("R2 not before poll", int_req, 0);
        poll = 1; step(); clr();
        chk("R2 edge latched", int_req, 1);
        serve(2'd2, 16'hFFFA, "nmi");
        ev_cli = 1; step(); clr();
        irq_n = 0; nmi_n = 0; step();
        poll = 1; step(); clr();
        chk("R7 both pending", int_req, 1);
        serve(2'd2, 16'hFFFA, "prio");
        irq_n = 1;
        poll = 1; step(); clr();
        chk("R2 held low once", int_req, 0);
        nmi_n = 1; step();
    endtask

    task automatic t_hijack();
        brk_go = 1; step(); clr();
        chk("R8 brk start", seq_force, 1);
        chk("R9 brk vec", vec_sel, 3);
        for (int i = 1; i < 5; i++) step();
        nmi_n = 0; step();
        chk("R9 at cyc5", seq_cyc, 5);
        chk("R9 hijacked sel", vec_sel, 2);
        chk("R9 hijacked addr", vec_addr, 16'hFFFA);
        step(); step();
        chk("R9 seq end", seq_force, 0);
        nmi_n = 1; poll = 1; step(); clr();
        chk("R9 nmi consumed", int_req, 0);
        brk_go = 1; step(); clr();
        for (int i = 1; i < 6; i++) step();
        chk("R9 late cyc5 vec", vec_sel, 3);
        nmi_n = 0; step();
        chk("R9 late no switch", vec_sel, 3);
        step(); nmi_n = 1;
        poll = 1; step(); clr();
        chk("R9 late stays pending", int_req, 1);
        serve(2'd2, 16'hFFFA, "late");
    endtask

    task automatic t_cpu_reset();
        int forced = 0;
        cpu_res_n = 0; step();
        chk("R10 hold force", seq_force, 1);
        chk("R10 vec_sel", vec_sel, 1);
        chk("R10 vec_addr", vec_addr, 16'hFFFC);
        chk("R10 hold cyc", seq_cyc, 0);
        cpu_res_n = 1;
        forced = 1;
        for (int i = 0; i < 10; i++) begin
            step();
            if (seq_force) forced++;
        end
        chk("R10 eight forced ticks", forced, 8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R11 actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset_state();
        t_irq_level();
        t_poll_gate();
        t_rti();
        t_late_flags();
        t_nmi();
        t_hijack();
        t_cpu_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule